// File: doc/BRIEF.md
# Sequential Hardware Breakpoint Comparator

This block watches a 32-bit CPU bus and raises a break request when a bus cycle matches one of four programmed breakpoint channels, named A to D. For every cycle the bus reports the address, the data, whether the CPU or another master drives it, whether it is an instruction fetch or a data access, its direction, and its size. Each channel compares the address under a per-bit mask and checks the cycle attributes against its qualifier bits. Channels C and D also compare the data under a mask. Both of them have a match counter, so they can break on the Nth occurrence instead of the first.

In sequential mode, channels C and D work as a chain. A match on C only arms the chain. A later match on D then raises the break and disarms the chain. Channels A and B keep breaking on their own in this mode. A fetch breakpoint fires on the fetch cycle itself, so the CPU can take the break before the fetched instruction executes.

The block is programmed through a single-cycle write port. Its output is a one-cycle break-request pulse, together with sticky per-channel flags that record which channels caused a break.

Top module: `bkp_unit`

## Requirements
- R1: After reset, `brk_req` is 0 and `brk_flags` is 0. All registers are 0, which makes every channel unused.
- R2: A channel's address compare ignores every bit whose address-mask bit is 1. With an all-zero mask, the address must match exactly.
- R3: Channels C and D also require `((bus_data ^ data) & ~data_mask) == 0`. Channels A and B ignore the bus data.
- R4: The qualifier register is 9 bits wide. Bit 0 selects CPU cycles and bit 1 selects other masters. Bit 2 selects fetches and bit 3 selects data accesses. Bit 4 selects reads and bit 5 selects writes. Bits 6, 7 and 8 select byte, word and longword (`bus_size` 0, 1, 2). A cycle matches only if the selected bit of every group is 1. Size 3 never matches, and a qualifier of 0 never matches.
- R5: A match during a cycle with `bus_valid` high gives `brk_req` = 1 for exactly the following clock cycle. A cycle with `bus_valid` low gives no request.
- R6: Bit i of `brk_flags` (A=0, B=1, C=2, D=3) is set by every break from channel i and stays set. Writing a 1 to control bit 8+i clears it. A new break in the same cycle wins over the clear.
- R7: When control bit 0 (sequential mode) is 1, a match on C sets an arm flag but raises no request and sets no flag. D breaks only when the arm flag was already set. A break from D clears the arm flag.
- R8: The arm flag is cleared by any register write and by any cycle in which sequential mode is off.
- R9: In sequential mode, channels A and B still break independently.
- R10: Counting for C is enabled by control bit 1, and counting for D by control bit 2. Each counter is loaded through its count register. With counting on, each match while the counter is above 1 decrements it and gives no break. A match with the counter at 1 or 0 breaks and leaves the counter unchanged.
- R11: The registers are indexed as follows. Index 0 is control. Indices 1+5c through 5+5c hold the address, address mask, qualifier, data and data mask of channel c. Index 21 holds C's count and index 22 holds D's count. Writes to the data slots of A and B are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_cpu | input | 1 | 1 = CPU master, 0 = other master |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | One-cycle break request |
| brk_flags | output | 4 | Sticky per-channel break flags |

## Verification
The assertions check the following on every cycle:
- a request always follows a valid bus cycle;
- idle cycles raise nothing;
- flags stay set until they are cleared;
- every request leaves a flag set;
- register writes and leaving sequential mode disarm the chain.

Only the bench's scenarios can show the rest: the masked compares, the qualifier decoding, the arming order of C before D, and the counts at which the counters start to break. These depend on programmed values and on the history of the cycles before.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  localparam int N_CH        = 4;
  localparam int CH_C        = 2;
  localparam int CH_D        = 3;
  localparam int QUAL_W      = 9;
  localparam int Q_CPU       = 0;
  localparam int Q_OTHER     = 1;
  localparam int Q_FETCH     = 2;
  localparam int Q_DATA      = 3;
  localparam int Q_RD        = 4;
  localparam int Q_WR        = 5;
  localparam int Q_SZ0       = 6;
  localparam int REG_CTRL    = 0;
  localparam int REG_CH0     = 1;
  localparam int REGS_PER_CH = 5;
  localparam int SLOT_ADDR   = 0;
  localparam int SLOT_AMASK  = 1;
  localparam int SLOT_QUAL   = 2;
  localparam int SLOT_DATA   = 3;
  localparam int SLOT_DMASK  = 4;
  localparam int REG_CNT_C   = REG_CH0 + N_CH * REGS_PER_CH;
  localparam int REG_CNT_D   = REG_CNT_C + 1;
  localparam int CTRL_SEQ    = 0;
  localparam int CTRL_CNT_C  = 1;
  localparam int CTRL_CNT_D  = 2;
  localparam int CTRL_CLR0   = 8;
endpackage

// File: rtl/bkp_regs.sv
module bkp_regs
  import bkp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 12,
  parameter int RA_W  = 5,
  parameter int REG_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [RA_W-1:0]               addr,
  input  logic [REG_W-1:0]              wdata,
  output logic                          seq_en,
  output logic                          cnt_en_c,
  output logic                          cnt_en_d,
  output logic [N_CH-1:0][AW-1:0]       cfg_addr,
  output logic [N_CH-1:0][AW-1:0]       cfg_amask,
  output logic [N_CH-1:0][QUAL_W-1:0]   cfg_qual,
  output logic [N_CH-1:0][DW-1:0]       cfg_data,
  output logic [N_CH-1:0][DW-1:0]       cfg_dmask,
  output logic [N_CH-1:0]               clr_flags,
  output logic                          load_c,
  output logic                          load_d,
  output logic [CW-1:0]                 load_val
);
  logic ctrl_hit;
  assign ctrl_hit  = we && (int'(addr) == REG_CTRL);
  assign clr_flags = ctrl_hit ? wdata[CTRL_CLR0 +: N_CH] : '0;
  assign load_c    = we && (int'(addr) == REG_CNT_C);
  assign load_d    = we && (int'(addr) == REG_CNT_D);
  assign load_val  = wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_en    <= 1'b0;
      cnt_en_c  <= 1'b0;
      cnt_en_d  <= 1'b0;
      cfg_addr  <= '0;
      cfg_amask <= '0;
      cfg_qual  <= '0;
      cfg_data  <= '0;
      cfg_dmask <= '0;
    end else if (we) begin
      if (ctrl_hit) begin
        seq_en   <= wdata[CTRL_SEQ];
        cnt_en_c <= wdata[CTRL_CNT_C];
        cnt_en_d <= wdata[CTRL_CNT_D];
      end
      for (int c = 0; c < N_CH; c++) begin
        if (int'(addr) == REG_CH0 + c*REGS_PER_CH + SLOT_ADDR)
          cfg_addr[c] <= wdata[AW-1:0];
        if (int'(addr) == REG_CH0 + c*REGS_PER_CH + SLOT_AMASK)
          cfg_amask[c] <= wdata[AW-1:0];
        if (int'(addr) == REG_CH0 + c*REGS_PER_CH + SLOT_QUAL)
          cfg_qual[c] <= wdata[QUAL_W-1:0];
        if (c >= CH_C) begin
          if (int'(addr) == REG_CH0 + c*REGS_PER_CH + SLOT_DATA)
            cfg_data[c] <= wdata[DW-1:0];
          if (int'(addr) == REG_CH0 + c*REGS_PER_CH + SLOT_DMASK)
            cfg_dmask[c] <= wdata[DW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bkp_channel.sv
module bkp_channel
  import bkp_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 12,
  parameter bit HAS_DATA = 1'b0,
  parameter bit HAS_CNT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic [AW-1:0]     cyc_addr,
  input  logic [DW-1:0]     cyc_data,
  input  logic              cyc_cpu,
  input  logic              cyc_fetch,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_size,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [AW-1:0]     cfg_amask,
  input  logic [QUAL_W-1:0] cfg_qual,
  input  logic [DW-1:0]     cfg_data,
  input  logic [DW-1:0]     cfg_dmask,
  input  logic              gate,
  input  logic              cnt_en,
  input  logic              cnt_load,
  input  logic [CW-1:0]     cnt_val,
  output logic              fire
);
  logic size_ok, attr_ok, addr_ok, data_ok, match;

  always_comb begin
    case (cyc_size)
      2'd0:    size_ok = cfg_qual[Q_SZ0];
      2'd1:    size_ok = cfg_qual[Q_SZ0+1];
      2'd2:    size_ok = cfg_qual[Q_SZ0+2];
      default: size_ok = 1'b0;
    endcase
  end

  assign attr_ok = cfg_qual[cyc_cpu   ? Q_CPU   : Q_OTHER]
                 & cfg_qual[cyc_fetch ? Q_FETCH : Q_DATA]
                 & cfg_qual[cyc_write ? Q_WR    : Q_RD]
                 & size_ok;
  assign addr_ok = ((cyc_addr ^ cfg_addr) & ~cfg_amask) == '0;

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ((cyc_data ^ cfg_data) & ~cfg_dmask) == '0;
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{cyc_data, cfg_data, cfg_dmask};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign match = cyc_valid & attr_ok & addr_ok & data_ok & gate;

  generate
    if (HAS_CNT) begin : g_cnt
      logic [CW-1:0] cnt_q;
      logic          at_limit;
      assign at_limit = (cnt_q <= CW'(1));
      assign fire     = match & (~cnt_en | at_limit);
      always_ff @(posedge clk) begin
        if (rst)                                cnt_q <= '0;
        else if (cnt_load)                      cnt_q <= cnt_val;
        else if (match && cnt_en && !at_limit)  cnt_q <= cnt_q - CW'(1);
      end
    end else begin : g_nocnt
      logic unused_cnt;
      assign unused_cnt = ^{clk, rst, cnt_en, cnt_load, cnt_val};
      assign fire = match;
    end
  endgenerate
endmodule

// File: rtl/bkp_unit.sv
module bkp_unit
  import bkp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 12,
  parameter int RA_W  = 5,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_cpu,
  input  logic             bus_fetch,
  input  logic             bus_write,
  input  logic [1:0]       bus_size,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             brk_req,
  output logic [N_CH-1:0]  brk_flags
);
  logic                        seq_en, cnt_en_c, cnt_en_d;
  logic [N_CH-1:0][AW-1:0]     cfg_addr, cfg_amask;
  logic [N_CH-1:0][QUAL_W-1:0] cfg_qual;
  logic [N_CH-1:0][DW-1:0]     cfg_data, cfg_dmask;
  logic [N_CH-1:0]             clr_flags, fire, fire_eff, gate, cnt_en, cnt_load;
  logic                        load_c, load_d;
  logic [CW-1:0]               load_val;
  logic                        seq_armed;

  bkp_regs #(.AW(AW), .DW(DW), .CW(CW), .RA_W(RA_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .seq_en(seq_en), .cnt_en_c(cnt_en_c), .cnt_en_d(cnt_en_d),
    .cfg_addr(cfg_addr), .cfg_amask(cfg_amask), .cfg_qual(cfg_qual),
    .cfg_data(cfg_data), .cfg_dmask(cfg_dmask), .clr_flags(clr_flags),
    .load_c(load_c), .load_d(load_d), .load_val(load_val)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign gate[c]     = (c == CH_D) ? (~seq_en | seq_armed) : 1'b1;
      assign cnt_en[c]   = (c == CH_C) ? cnt_en_c : (c == CH_D) ? cnt_en_d : 1'b0;
      assign cnt_load[c] = (c == CH_C) ? load_c   : (c == CH_D) ? load_d   : 1'b0;
      bkp_channel #(
        .AW(AW), .DW(DW), .CW(CW),
        .HAS_DATA(c >= CH_C), .HAS_CNT(c >= CH_C)
      ) u_ch (
        .clk(clk), .rst(rst), .cyc_valid(bus_valid), .cyc_addr(bus_addr),
        .cyc_data(bus_data), .cyc_cpu(bus_cpu), .cyc_fetch(bus_fetch),
        .cyc_write(bus_write), .cyc_size(bus_size),
        .cfg_addr(cfg_addr[c]), .cfg_amask(cfg_amask[c]), .cfg_qual(cfg_qual[c]),
        .cfg_data(cfg_data[c]), .cfg_dmask(cfg_dmask[c]), .gate(gate[c]),
        .cnt_en(cnt_en[c]), .cnt_load(cnt_load[c]), .cnt_val(load_val),
        .fire(fire[c])
      );
    end
  endgenerate

  always_comb begin
    fire_eff = fire;
    if (seq_en) fire_eff[CH_C] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || reg_we || !seq_en) seq_armed <= 1'b0;
    else                          seq_armed <= fire[CH_C] | (seq_armed & ~fire[CH_D]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req   <= 1'b0;
      brk_flags <= '0;
    end else begin
      brk_req   <= |fire_eff;
      brk_flags <= (brk_flags & ~clr_flags) | fire_eff;
    end
  end
endmodule

// File: rtl/bkp_unit_chk.sv
module bkp_unit_chk
  import bkp_pkg::*;
#(
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_valid,
  input logic            reg_we,
  input logic [RA_W-1:0] reg_addr,
  input logic            brk_req,
  input logic [N_CH-1:0] brk_flags,
  input logic            seq_en,
  input logic            seq_armed
);
  a_r5_req_needs_cycle: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(bus_valid));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !brk_req);
  a_r6_flags_with_req: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (brk_flags != '0));
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && int'(reg_addr) == REG_CTRL) |=>
      ((brk_flags & $past(brk_flags)) == $past(brk_flags)));
  a_r8_write_disarms: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !seq_armed);
  a_r8_seq_off_disarms: assert property (@(posedge clk) disable iff (rst)
    !seq_en |=> !seq_armed);
endmodule

bind bkp_unit bkp_unit_chk #(.RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .brk_req(brk_req), .brk_flags(brk_flags),
  .seq_en(seq_en), .seq_armed(seq_armed)
);

// File: tb/tb_bkp_unit.sv
module tb_bkp_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_cpu, bus_fetch, bus_write;
  logic [31:0] bus_addr, bus_data;
  logic [1:0]  bus_size;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        brk_req;
  logic [3:0]  brk_flags;
  int          total = 0;
  int          bad   = 0;

  always #2.5 clk = ~clk;

  bkp_unit dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_cpu(bus_cpu), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .bus_size(bus_size), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .brk_req(brk_req),
    .brk_flags(brk_flags)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic        cpu;
    logic        fetch;
    logic        wr;
    logic [1:0]  sz;
    logic        req;
    logic [3:0]  flg;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h1000, 32'h0,        1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 4'b0001, 8'd2}, // R2 A exact
    '{32'h1000, 32'h0,        1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4'b0001, 8'd4}, // R4 size
    '{32'h1000, 32'h0,        1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'b0001, 8'd4}, // R4 master
    '{32'h1002, 32'h0,        1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'b0001, 8'd2}, // R2 exact miss
    '{32'h20AB, 32'hDEADBEEF, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 4'b0011, 8'd3}, // R2 R3 B masked, data ignored
    '{32'h21AB, 32'h0,        1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'b0011, 8'd2}, // R2 unmasked bit
    '{32'h2010, 32'h0,        1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 4'b0011, 8'd4}, // R4 direction
    '{32'h3000, 32'hCAFE1234, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 4'b0111, 8'd3}, // R3 data mask
    '{32'h3000, 32'hCAFF0000, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 4'b0111, 8'd3}, // R3 data miss
    '{32'h0,    32'h0,        1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'b0111, 8'd4}, // R4 D unused
    '{32'h1000, 32'h0,        1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 4'b0111, 8'd4}, // R4 fetch vs data
    '{32'h1000, 32'h0,        1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 4'b0111, 8'd4}  // R4 size 3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(idx); reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic cpu,
                     input logic fetch, input logic w, input logic [1:0] sz);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d;
    bus_cpu = cpu; bus_fetch = fetch; bus_write = w; bus_size = sz;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_valid = 1'b0; bus_addr = '0; bus_data = '0; bus_cpu = 1'b0;
    bus_fetch = 1'b0; bus_write = 1'b0; bus_size = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req after reset", 32'(brk_req), 32'd0);
    chk("R1 flags after reset", 32'(brk_flags), 32'd0);
    cyc(32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R1 unprogrammed channels silent", 32'(brk_req), 32'd0);

    // R11 map: A base 1, B base 6, C base 11, D base 16
    wr(1, 32'h1000);  wr(2, 32'h0);  wr(3, 32'h095);
    wr(6, 32'h2000);  wr(7, 32'hFF); wr(8, 32'h1EB);
    wr(9, 32'hFFFFFFFF);             // R11 B data slot discarded
    wr(11, 32'h3000); wr(12, 32'h0); wr(13, 32'h139);
    wr(14, 32'hCAFE0000); wr(15, 32'h0000FFFF);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].a, VEC[i].d, VEC[i].cpu, VEC[i].fetch, VEC[i].wr, VEC[i].sz);
      chk($sformatf("R%0d vec%0d req", VEC[i].rq, i), 32'(brk_req), 32'(VEC[i].req));
      chk($sformatf("R6 vec%0d flags", i), 32'(brk_flags), 32'(VEC[i].flg));
    end

    // R5 idle cycle with a matching address
    @(negedge clk);
    bus_addr = 32'h1000; bus_cpu = 1'b1; bus_fetch = 1'b1; bus_write = 1'b0; bus_size = 2'd1;
    @(negedge clk);
    chk("R5 invalid cycle", 32'(brk_req), 32'd0);
    // R5 a single match gives a request for one cycle only
    cyc(32'h1000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R5 pulse high", 32'(brk_req), 32'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(brk_req), 32'd0);

    // R6 clear flags A and B only
    wr(0, 32'h300);
    chk("R6 partial clear", 32'(brk_flags), 32'b0100);

    // R7 sequential mode: D at 0x4000 fetch, C on writes
    wr(16, 32'h4000); wr(17, 32'h0); wr(18, 32'h095); wr(20, 32'hFFFFFFFF);
    wr(13, 32'h129);
    wr(0, 32'hF01);
    chk("R6 full clear", 32'(brk_flags), 32'd0);
    cyc(32'h4000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R7 D without C", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE0000, 1'b1, 1'b0, 1'b0, 2'd2);
    cyc(32'h4000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R7 C read does not arm", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R7 C arms silently req", 32'(brk_req), 32'd0);
    chk("R7 C arms silently flags", 32'(brk_flags), 32'd0);
    cyc(32'h4000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R7 D after C", 32'(brk_req), 32'd1);
    chk("R7 D flag", 32'(brk_flags), 32'b1000);
    cyc(32'h4000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R7 D disarms", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    wr(1, 32'h1000);
    cyc(32'h4000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R8 write disarms", 32'(brk_req), 32'd0);
    cyc(32'h1000, 32'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R9 A independent", 32'(brk_req), 32'd1);
    chk("R9 A flag", 32'(brk_flags), 32'b1001);

    // R10 counting on C, sequential mode off
    wr(0, 32'h002);
    wr(21, 32'd3);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 count 1st", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 count 2nd", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 count 3rd", 32'(brk_req), 32'd1);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 count holds", 32'(brk_req), 32'd1);
    wr(21, 32'd2);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 reload 1st", 32'(brk_req), 32'd0);
    cyc(32'h3000, 32'hCAFE5555, 1'b1, 1'b0, 1'b1, 2'd2);
    chk("R10 reload 2nd", 32'(brk_req), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule